// File: doc/BRIEF.md
# Round-Robin Cell Queue Selector

This block decides which of four cell queues feeds a shared output. It changes the choice only between whole cells. When the sequencer is enabled, it rotates through the queues that hold a complete cell. On each new choice it presents the 2-bit queue number and raises a one-cycle load strobe. A second device can capture that number on the following clock edge.

When the sequencer is disabled, the address and strobe pins become inputs. External logic then names the queue. A strobe captures the external address, and that address takes effect at the next cell boundary.

A lead/follow select decides whether an enabled device actually drives its address and strobe pins. The pins are driven through output-enable signals, so two devices can share the same wires. A cell-done input marks the end of the cell now being transferred.

Top module: `cell_rr_selector`

## Requirements
- R1: A synchronous active-high reset sets the selection to queue 3, marks no cell in progress and clears the strobe. The first rotated pick after reset is therefore queue 0.
- R2: In sequencer mode, a boundary is a cycle with no cell in progress, or a cycle with `cell_done` high. At a boundary with at least one `q_ready` bit set (bit i belongs to queue i), the next selection is the first ready queue in the order sel+1, sel+2, sel+3, sel (modulo 4). `cell_active` then goes high. `qaddr_out` bit 0 is the LSB of the queue number.
- R3: `ldstb_out` is high for exactly the cycle after each sequencer pick, together with the new address. It is low in every other cycle.
- R4: While a cell is in progress and `cell_done` is low, the selection does not change in either mode.
- R5: In sequencer mode, a boundary with no ready queue keeps the selection. It drops `cell_active` and raises no strobe.
- R6: `qaddr_oe` (both bits) and `ldstb_oe` are high exactly when `seq_en` and `lead_sel` are both high. With `seq_en` high and `lead_sel` low, the sequencer still runs but drives no pins.
- R7: With `seq_en` low, `ldstb_in` captures `qaddr_in` (bit 0 LSB). A capture made mid-cell is applied at the next boundary. A capture made at a boundary is applied at once, and `cell_active` goes high.
- R8: With `seq_en` low, `q_ready` has no effect. A boundary with no pending capture keeps the selection and drops `cell_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 1 | 1: internal rotation; 0: pins are inputs |
| lead_sel | input | 1 | 1: lead device (drives pins when rotating), 0: follower |
| q_ready | input | 4 | Per-queue complete-cell-available flags |
| cell_done | input | 1 | Current cell transfer ends this cycle |
| qaddr_in | input | 2 | External queue number (manual mode) |
| ldstb_in | input | 1 | External load strobe (manual mode) |
| qaddr_out | output | 2 | Current selected queue number |
| qaddr_oe | output | 2 | Drive enables for the address pins |
| ldstb_out | output | 1 | Load strobe to a follower |
| ldstb_oe | output | 1 | Drive enable for the strobe pin |
| cell_active | output | 1 | A cell from the selected queue is in progress |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a known value from time zero. They also assume that `cell_done` matters only while a cell is in progress. The block tolerates `cell_done` when idle, because idle is already a boundary. The stimulus drives all inputs on the falling edge from a seeded random source. It moves through phases of leading rotation, following rotation and manual control, with occasional resets. It stays inside those assumptions while still reaching strobes that coincide with boundaries and back-to-back cells.

// File: rtl/cellseq_pkg.sv
package cellseq_pkg;
    parameter int unsigned NQ = 4;
    localparam int unsigned QW = $clog2(NQ);

    typedef logic [QW-1:0] qid_t;

    typedef struct packed {
        qid_t sel;
        logic busy;
        logic stb;
    } seq_state_t;

    localparam qid_t RESET_SEL = qid_t'(NQ - 1);

    // First ready queue after 'last' in rotating order, 'last' itself checked last.
    function automatic qid_t rr_pick(input qid_t last, input logic [NQ-1:0] rdy);
        qid_t r;
        r = last;
        for (int k = NQ; k >= 1; k--) begin
            qid_t idx;
            idx = qid_t'((int'(last) + k) % NQ);
            if (rdy[idx]) r = idx;
        end
        return r;
    endfunction
endpackage

// File: rtl/cellseq_picker.sv
module cellseq_picker
    import cellseq_pkg::*;
(
    input  qid_t          last,
    input  logic [NQ-1:0] rdy,
    output qid_t          pick,
    output logic          any
);
    always_comb begin
        pick = rr_pick(last, rdy);
        any  = |rdy;
    end
endmodule

// File: rtl/cellseq_capture.sv
module cellseq_capture
    import cellseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic seq_en,
    input  logic boundary,
    input  logic ld_in,
    input  qid_t addr_in,
    output logic take,
    output qid_t take_addr
);
    qid_t pend;
    logic pend_v;

    always_ff @(posedge clk) begin
        if (rst || seq_en) begin
            pend_v <= 1'b0;
            pend   <= '0;
        end else if (boundary) begin
            pend_v <= 1'b0;
        end else if (ld_in) begin
            pend   <= addr_in;
            pend_v <= 1'b1;
        end
    end

    always_comb begin
        take      = !seq_en && boundary && (ld_in || pend_v);
        take_addr = ld_in ? addr_in : pend;
    end
endmodule

// File: rtl/cellseq_pins.sv
module cellseq_pins
    import cellseq_pkg::*;
(
    input  logic          seq_en,
    input  logic          lead_sel,
    output logic [QW-1:0] addr_oe,
    output logic          stb_oe
);
    logic drive;
    always_comb begin
        drive   = seq_en && lead_sel;
        addr_oe = {QW{drive}};
        stb_oe  = drive;
    end
endmodule

// File: rtl/cell_rr_selector.sv
module cell_rr_selector
    import cellseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          seq_en,
    input  logic          lead_sel,
    input  logic [NQ-1:0] q_ready,
    input  logic          cell_done,
    input  logic [QW-1:0] qaddr_in,
    input  logic          ldstb_in,
    output logic [QW-1:0] qaddr_out,
    output logic [QW-1:0] qaddr_oe,
    output logic          ldstb_out,
    output logic          ldstb_oe,
    output logic          cell_active
);
    seq_state_t st, st_nx;
    qid_t       pick, take_addr;
    logic       any_rdy, take, boundary;

    assign boundary = !st.busy || cell_done;

    cellseq_picker u_pick (
        .last (st.sel),
        .rdy  (q_ready),
        .pick (pick),
        .any  (any_rdy)
    );

    cellseq_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .seq_en    (seq_en),
        .boundary  (boundary),
        .ld_in     (ldstb_in),
        .addr_in   (qaddr_in),
        .take      (take),
        .take_addr (take_addr)
    );

    cellseq_pins u_pins (
        .seq_en   (seq_en),
        .lead_sel (lead_sel),
        .addr_oe  (qaddr_oe),
        .stb_oe   (ldstb_oe)
    );

    always_comb begin
        st_nx     = st;
        st_nx.stb = 1'b0;
        if (boundary) begin
            if (seq_en) begin
                if (any_rdy) begin
                    st_nx.sel  = pick;
                    st_nx.busy = 1'b1;
                    st_nx.stb  = 1'b1;
                end else begin
                    st_nx.busy = 1'b0;
                end
            end else if (take) begin
                st_nx.sel  = take_addr;
                st_nx.busy = 1'b1;
            end else begin
                st_nx.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.sel  <= RESET_SEL;
            st.busy <= 1'b0;
            st.stb  <= 1'b0;
        end else begin
            st <= st_nx;
        end
    end

    assign qaddr_out   = st.sel;
    assign ldstb_out   = st.stb;
    assign cell_active = st.busy;

    p_hold_midcell_r4: assert property (@(posedge clk) disable iff (rst)
        cell_active && !cell_done |=> $stable(qaddr_out));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        seq_en && (!cell_active || cell_done) && (q_ready == '0)
        |=> $stable(qaddr_out) && !ldstb_out && !cell_active);

    p_grant_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        seq_en && (!cell_active || cell_done) && (q_ready != '0)
        |=> ldstb_out && cell_active);

    p_strobe_src_r3: assert property (@(posedge clk) disable iff (rst)
        ldstb_out |-> $past(seq_en));

    p_drive_mode_r6: assert property (@(posedge clk) disable iff (rst)
        ldstb_oe |-> seq_en && lead_sel);

    p_manual_take_r7: assert property (@(posedge clk) disable iff (rst)
        !seq_en && (!cell_active || cell_done) && ldstb_in
        |=> qaddr_out == $past(qaddr_in) && cell_active);
endmodule

// File: tb/cell_rr_selector_test.sv
module cell_rr_selector_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1, seq_en = 1'b0, lead_sel = 1'b0, cell_done = 1'b0, ldstb_in = 1'b0;
    logic [3:0] q_ready = 4'h0;
    logic [1:0] qaddr_in = 2'd0;
    logic [1:0] qaddr_out, qaddr_oe;
    logic       ldstb_out, ldstb_oe, cell_active;

    int n_chk = 0, n_bad = 0;
    logic finished = 1'b0;

    logic [1:0] m_sel = 2'd3, m_pend = 2'd0;
    logic       m_busy = 1'b0, m_stb = 1'b0, m_pv = 1'b0;

    always #5 clk = ~clk;

    cell_rr_selector uut (
        .clk(clk), .rst(rst), .seq_en(seq_en), .lead_sel(lead_sel),
        .q_ready(q_ready), .cell_done(cell_done), .qaddr_in(qaddr_in),
        .ldstb_in(ldstb_in), .qaddr_out(qaddr_out), .qaddr_oe(qaddr_oe),
        .ldstb_out(ldstb_out), .ldstb_oe(ldstb_oe), .cell_active(cell_active)
    );

    function automatic logic [1:0] exp_pick(input logic [1:0] last, input logic [3:0] rdy);
        logic [1:0] r = last;
        for (int k = 4; k >= 1; k--) begin
            logic [1:0] idx = 2'(last + 2'(k));
            if (rdy[idx]) r = idx;
        end
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic se, input logic ls, input logic [3:0] rdy,
                        input logic cd, input logic li, input logic [1:0] ai);
        string tag;
        logic  bnd;
        rst = r; seq_en = se; lead_sel = ls; q_ready = rdy;
        cell_done = cd; ldstb_in = li; qaddr_in = ai;
        bnd = !m_busy || cd;
        if (r) tag = "R1";
        else if (!bnd) tag = "R4";
        else if (se) tag = (rdy != 4'h0) ? "R2" : "R5";
        else tag = (li || m_pv) ? "R7" : "R8";
        @(posedge clk);
        if (r) begin
            m_sel = 2'd3; m_busy = 1'b0; m_stb = 1'b0; m_pv = 1'b0; m_pend = 2'd0;
        end else if (se) begin
            m_pv = 1'b0;
            m_stb = 1'b0;
            if (bnd) begin
                if (rdy != 4'h0) begin
                    m_sel = exp_pick(m_sel, rdy); m_busy = 1'b1; m_stb = 1'b1;
                end else m_busy = 1'b0;
            end
        end else begin
            m_stb = 1'b0;
            if (bnd) begin
                if (li) begin m_sel = ai; m_busy = 1'b1; m_pv = 1'b0; end
                else if (m_pv) begin m_sel = m_pend; m_busy = 1'b1; m_pv = 1'b0; end
                else m_busy = 1'b0;
            end else if (li) begin
                m_pend = ai; m_pv = 1'b1;
            end
        end
        @(negedge clk);
        check(tag, int'(qaddr_out), int'(m_sel));
        check(tag, int'(cell_active), int'(m_busy));
        check(r ? "R1" : "R3", int'(ldstb_out), int'(m_stb));
        check("R6", int'(qaddr_oe), (se && ls) ? 3 : 0);
        check("R6", int'(ldstb_oe), int'(se && ls));
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1 reset state
        step(1, 1, 1, 4'hF, 0, 0, 0);
        step(1, 1, 1, 4'h0, 0, 0, 0);
        // R5: nothing ready keeps queue 3 and stays idle
        for (int i = 0; i < 3; i++) step(0, 1, 1, 4'h0, 0, 0, 0);
        // R2: only queue 2 ready, repeated cells from the same queue
        step(0, 1, 1, 4'b0100, 0, 0, 0);
        step(0, 1, 1, 4'b0100, 0, 0, 0);   // R4 hold mid-cell
        step(0, 1, 1, 4'b0100, 1, 0, 0);
        // R2: all ready, rotation 3,0,1
        step(0, 1, 1, 4'hF, 1, 0, 0);
        step(0, 1, 1, 4'hF, 1, 0, 0);
        step(0, 1, 1, 4'hF, 1, 0, 0);
        // R6: follower runs without driving
        step(0, 1, 0, 4'b1000, 1, 0, 0);
        // R7: manual capture mid-cell, applied at boundary
        step(0, 0, 0, 4'hF, 0, 1, 2'd1);
        step(0, 0, 0, 4'hF, 0, 0, 2'd2);
        step(0, 0, 0, 4'hF, 1, 0, 2'd2);
        // R7: capture at boundary applies at once; R8 ready ignored
        step(0, 0, 1, 4'hF, 1, 1, 2'd3);
        step(0, 0, 1, 4'hF, 1, 0, 2'd0);
        step(0, 0, 1, 4'hF, 1, 0, 2'd0);
        // random phases
        for (int ph = 0; ph < 60; ph++) begin
            int mode = int'($urandom_range(0, 3));
            for (int c = 0; c < 50; c++) begin
                logic rr = ($urandom_range(0, 199) == 0);
                logic se = (mode != 3);
                logic ls = (mode != 2);
                step(rr, se, ls, 4'($urandom), ($urandom_range(0, 3) == 0),
                     ($urandom_range(0, 4) == 0), 2'($urandom));
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule